// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external memory bus for a processor core whose machine cycle is four clocks. The core hands it one request at a time, which can be an instruction fetch, a data read or a data write. The block then plays that request out on a byte-wide bus. On the first clock the low address byte is driven alongside a latch-enable pulse. After that the same pins carry data: the block drives them for a write and leaves them floating for a read. The upper address byte sits on its own output for the whole access.

Fetches always take one machine cycle and strobe the active-low program-store enable. Data accesses use separate active-low read and write strobes. Their length is set by a 3-bit stretch register, which gives two to nine machine cycles so that slow RAM or peripherals can sit on the same bus. For a data access, the upper address byte comes either from the upper byte of a 16-bit pointer or, for an 8-bit register-indirect access, from a byte latch that software has written. Each access ends with a one-clock ready pulse, and any read data is valid on the captured-data output during that pulse.

The sequencer has five states. **IDLE** waits for a request. **LATCH** pulses the latch enable with the low address on the bus. **HOLD** is the first clock after the latch enable falls. **STROBE** asserts the access strobe for a counted number of clocks. **RECOVER** keeps all strobes high before the access ends. The transitions are:
- *accept*: IDLE→LATCH, on a request.
- *latch_done*: LATCH→HOLD.
- *strobe_on*: HOLD→STROBE.
- *strobe_off*: STROBE→RECOVER, when the strobe counter is spent.
- *finish*: RECOVER→IDLE, when the recovery counter is spent.

Top module: `xbus_seq`

## Requirements
- R1: While `rst` is high, the outputs hold these values: `ale`=1, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=1, `ad_out`=8'hFF, `addr_hi`=8'hFF and `ready`=0.
- R2: In the first clock after a request is accepted (an accept is `req_valid` high at a rising edge while idle), `ale` is 1, `ad_oe` is 1 and `ad_out` carries `req_addr[7:0]`. `ale` is 0 in every other clock outside reset. In the second clock of a fetch or read, the low address is still driven.
- R3: A fetch (`req_kind`=2'b00) lasts 4 clocks. `psen_n` is low only in clock 3. `ad_oe` is 0 in clocks 3 and 4.
- R4: A data access lasts 4*(S+2) clocks, where S is the stretch register value (0 gives 8 clocks, 7 gives 36). The stretch register loads `stretch_wdata` on a clock edge with `stretch_we` high. Its reset value is 1.
- R5: A data read (`req_kind`=2'b01, with 2'b11 treated as a read) holds `rd_n` low from clock 3 to clock 4*(S+2)-2. From clock 3 on, `ad_oe` is 0. `ad_in` is captured at the rising edge of `rd_n`; the same rule applies at the rising edge of `psen_n` for a fetch.
- R6: A data write (`req_kind`=2'b10) holds `wr_n` low over the same clocks as the read strobe. `ad_oe` is 1 with `ad_out`=`req_wdata` from clock 2 to the last clock, so the data outlasts the strobe by two clocks.
- R7: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time. `psen_n` stays high during data accesses, and `rd_n` and `wr_n` stay high during fetches.
- R8: `addr_hi` equals `req_addr[15:8]` for fetches and for data accesses with `req_wide`=1. With `req_wide`=0 it equals the `hiport` value sampled at accept. It holds that value for the whole access.
- R9: `ready` is high for exactly one clock, the last clock of the access. In that clock `rdata` holds the captured read data.
- R10: A stretch write made while an access is under way leaves that access's length unchanged and applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| req_valid | input | 1 | Access request, accepted while idle |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_wide | input | 1 | 1: 16-bit pointer access; 0: 8-bit register address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| hiport | input | 8 | Software-written high address latch |
| stretch_we | input | 1 | Stretch register write enable |
| stretch_wdata | input | 3 | Stretch register write value |
| ready | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured read or fetch data |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Multiplexed bus drive value |
| ad_oe | output | 1 | Multiplexed bus output enable |
| ad_in | input | 8 | Multiplexed bus input value |

## Verification
The bench builds the block with its default parameters: four clocks per machine cycle and a 3-bit stretch field. This makes all eight stretch codes reachable, from the shortest 8-clock data access to the longest 36-clock one. Seeded random fetches, reads and writes are mixed with directed cases: the reset-default stretch, both extreme stretch codes, the duplicate read code, and a stretch write made in the middle of an access. Read data on the bus is changed before the strobe and again after it, so capturing on the wrong edge shows up as a mismatch.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_HOLD,
        ST_STROBE,
        ST_RECOVER
    } bus_state_e;

endpackage

// File: rtl/xbus_stretch_reg.sv
module xbus_stretch_reg #(
    parameter int STRETCH_W   = 3,
    parameter int STRETCH_RST = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [STRETCH_W-1:0] wdata,
    output logic [STRETCH_W-1:0] stretch
);

    localparam logic [STRETCH_W-1:0] RST_VAL = STRETCH_W'(STRETCH_RST);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stretch <= RST_VAL;
        end else if (we) begin
            stretch <= wdata;
        end
    end

endmodule

// File: rtl/xbus_req_capture.sv
module xbus_req_capture
    import xbus_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STRETCH_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept,
    input  logic [1:0]            req_kind,
    input  logic                  req_wide,
    input  logic [2*BYTE_W-1:0]   req_addr,
    input  logic [BYTE_W-1:0]     req_wdata,
    input  logic [BYTE_W-1:0]     hiport,
    input  logic [STRETCH_W-1:0]  stretch_in,
    output acc_kind_e             kind_q,
    output logic [BYTE_W-1:0]     lo_q,
    output logic [BYTE_W-1:0]     hi_q,
    output logic [BYTE_W-1:0]     wdata_q,
    output logic [STRETCH_W-1:0]  stretch_q
);

    acc_kind_e         kind_dec;
    logic [BYTE_W-1:0] hi_sel;

    // The spare code is folded onto a data read.
    always_comb begin
        unique case (req_kind)
            2'b00:   kind_dec = ACC_FETCH;
            2'b10:   kind_dec = ACC_WRITE;
            default: kind_dec = ACC_READ;
        endcase
    end

    // Fetches and pointer accesses use the address upper byte; register-indirect
    // data accesses use the software latch.
    always_comb begin
        if (kind_dec == ACC_FETCH || req_wide) begin
            hi_sel = req_addr[2*BYTE_W-1:BYTE_W];
        end else begin
            hi_sel = hiport;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            kind_q    <= ACC_FETCH;
            lo_q      <= '1;
            hi_q      <= '1;
            wdata_q   <= '0;
            stretch_q <= '0;
        end else if (accept) begin
            kind_q    <= kind_dec;
            lo_q      <= req_addr[BYTE_W-1:0];
            hi_q      <= hi_sel;
            wdata_q   <= req_wdata;
            stretch_q <= stretch_in;
        end
    end

endmodule

// File: rtl/xbus_rdcap.sv
module xbus_rdcap #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [BYTE_W-1:0] ad_in,
    output logic [BYTE_W-1:0] rdata
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rdata <= '0;
        end else if (cap_en) begin
            rdata <= ad_in;
        end
    end

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int CLK_PER_MC = 4,
    parameter int STRETCH_W  = 3,
    parameter int BYTE_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  acc_kind_e            kind,
    input  logic [STRETCH_W-1:0] stretch,
    input  logic [BYTE_W-1:0]    lo,
    input  logic [BYTE_W-1:0]    wdata,
    output logic                 accept,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 ad_oe,
    output logic [BYTE_W-1:0]    ad_out,
    output logic                 ready,
    output logic                 cap_en
);

    // Longest access in clocks and the counter that spans it.
    localparam int MAX_LEN = CLK_PER_MC * ((1 << STRETCH_W) + 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] MC_LEN = CNT_W'(CLK_PER_MC);
    // Fixed clocks outside the strobe: latch, hold, and the recovery clocks.
    localparam logic [CNT_W-1:0] FETCH_FIXED = CNT_W'(3);
    localparam logic [CNT_W-1:0] DATA_FIXED  = CNT_W'(4);

    bus_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [CNT_W-1:0] data_len;
    logic [CNT_W-1:0] strobe_load;
    logic [CNT_W-1:0] recov_load;
    logic             is_fetch;
    logic             is_write;

    assign is_fetch = (kind == ACC_FETCH);
    assign is_write = (kind == ACC_WRITE);
    assign accept   = (state == ST_IDLE) && req_valid;

    // Data access length: (stretch + 2) machine cycles.
    assign data_len = MC_LEN * (CNT_W'(stretch) + CNT_W'(2));

    always_comb begin
        if (is_fetch) begin
            strobe_load = MC_LEN - FETCH_FIXED - CNT_W'(1);
            recov_load  = '0;
        end else begin
            strobe_load = data_len - DATA_FIXED - CNT_W'(1);
            recov_load  = CNT_W'(1);
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) state_nxt = ST_LATCH;
            end
            ST_LATCH: begin
                state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                state_nxt = ST_STROBE;
                cnt_nxt   = strobe_load;
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    state_nxt = ST_RECOVER;
                    cnt_nxt   = recov_load;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            ST_RECOVER: begin
                if (cnt == '0) begin
                    state_nxt = ST_IDLE;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Output decode.
    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '1;
        ready  = 1'b0;
        cap_en = 1'b0;
        if (rst) begin
            ale   = 1'b1;
            ad_oe = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_LATCH: begin
                    ale    = 1'b1;
                    ad_oe  = 1'b1;
                    ad_out = lo;
                end
                ST_HOLD: begin
                    ad_oe  = 1'b1;
                    ad_out = is_write ? wdata : lo;
                end
                ST_STROBE: begin
                    if (is_write) begin
                        ad_oe  = 1'b1;
                        ad_out = wdata;
                        wr_n   = 1'b0;
                    end else begin
                        if (is_fetch) psen_n = 1'b0;
                        else          rd_n   = 1'b0;
                        cap_en = (cnt == '0);
                    end
                end
                ST_RECOVER: begin
                    if (is_write) begin
                        ad_oe  = 1'b1;
                        ad_out = wdata;
                    end
                    ready = (cnt == '0);
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int STRETCH_W   = 3,
    parameter int STRETCH_RST = 1,
    parameter int CLK_PER_MC  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic                 req_wide,
    input  logic [2*BYTE_W-1:0]  req_addr,
    input  logic [BYTE_W-1:0]    req_wdata,
    input  logic [BYTE_W-1:0]    hiport,
    input  logic                 stretch_we,
    input  logic [STRETCH_W-1:0] stretch_wdata,
    output logic                 ready,
    output logic [BYTE_W-1:0]    rdata,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [BYTE_W-1:0]    addr_hi,
    output logic [BYTE_W-1:0]    ad_out,
    output logic                 ad_oe,
    input  logic [BYTE_W-1:0]    ad_in
);

    logic                 accept;
    logic                 cap_en;
    logic [STRETCH_W-1:0] stretch_cur;
    logic [STRETCH_W-1:0] stretch_q;
    acc_kind_e            kind_q;
    logic [BYTE_W-1:0]    lo_q;
    logic [BYTE_W-1:0]    wdata_q;

    xbus_stretch_reg #(
        .STRETCH_W   (STRETCH_W),
        .STRETCH_RST (STRETCH_RST)
    ) u_stretch (
        .clk     (clk),
        .rst     (rst),
        .we      (stretch_we),
        .wdata   (stretch_wdata),
        .stretch (stretch_cur)
    );

    xbus_req_capture #(
        .BYTE_W    (BYTE_W),
        .STRETCH_W (STRETCH_W)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_kind   (req_kind),
        .req_wide   (req_wide),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .hiport     (hiport),
        .stretch_in (stretch_cur),
        .kind_q     (kind_q),
        .lo_q       (lo_q),
        .hi_q       (addr_hi),
        .wdata_q    (wdata_q),
        .stretch_q  (stretch_q)
    );

    xbus_fsm #(
        .CLK_PER_MC (CLK_PER_MC),
        .STRETCH_W  (STRETCH_W),
        .BYTE_W     (BYTE_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .kind      (kind_q),
        .stretch   (stretch_q),
        .lo        (lo_q),
        .wdata     (wdata_q),
        .accept    (accept),
        .ale       (ale),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out),
        .ready     (ready),
        .cap_en    (cap_en)
    );

    xbus_rdcap #(
        .BYTE_W (BYTE_W)
    ) u_rdcap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .ad_in  (ad_in),
        .rdata  (rdata)
    );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic ready
);

    // R1
    always @(posedge clk) begin
        if (rst) begin
            rst_quiet_chk: assert (ale && psen_n && rd_n && wr_n && ad_oe && !ready);
        end
    end

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R2
    ale_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> ad_oe);

    // R3
    psen_one_chk: assert property (@(posedge clk) disable iff (rst)
        !psen_n |=> psen_n);

    // R5
    rd_float_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

endmodule

bind xbus_seq xbus_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .psen_n (psen_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .ad_oe  (ad_oe),
    .ready  (ready)
);

// File: tb/xbus_seq_test.sv
module xbus_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic [7:0]  hiport = 8'h0;
    logic        stretch_we = 1'b0;
    logic [2:0]  stretch_wdata = 3'd0;
    logic        ready;
    logic [7:0]  rdata;
    logic        ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  addr_hi, ad_out;
    logic [7:0]  ad_in = 8'h00;

    int n_chk  = 0;
    int n_fail = 0;
    int cur_st = 1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xbus_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .hiport(hiport), .stretch_we(stretch_we), .stretch_wdata(stretch_wdata),
        .ready(ready), .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected {ale, psen_n, rd_n, wr_n, ad_oe} for clock t of an access of length len.
    function automatic logic [4:0] exp_ctrl(input int k, input int t, input int len);
        logic a, p, r, w, o;
        a = (t == 0);
        p = !(k == 0 && t >= 2 && t <= len - 2);
        r = !(k == 1 && t >= 2 && t <= len - 3);
        w = !(k == 2 && t >= 2 && t <= len - 3);
        o = (t < 2) || (k == 2);
        return {a, p, r, w, o};
    endfunction

    function automatic logic [7:0] exp_bus(input int k, input int t,
                                           input logic [15:0] a, input logic [7:0] wd);
        if (t == 0 || k != 2) return a[7:0];
        return wd;
    endfunction

    task automatic set_stretch(input int v);
        @(negedge clk);
        stretch_we    = 1'b1;
        stretch_wdata = 3'(v);
        @(negedge clk);
        stretch_we    = 1'b0;
        cur_st        = v;
    endtask

    task automatic access(input int k, input bit wide, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] hp,
                          input logic [7:0] bv, input int mid_st);
        int         ek;
        int         len;
        int         chg;
        logic [7:0] ehi;
        string      tag;
        string      ltag;
        ek   = (k == 3) ? 1 : k;
        len  = (ek == 0) ? 4 : 4 * (cur_st + 2);
        chg  = (ek == 0) ? len - 1 : len - 2;
        ehi  = (ek == 0 || wide) ? a[15:8] : hp;
        tag  = (ek == 0) ? "R3 R2 R7" : (ek == 1) ? "R5 R2 R7" : "R6 R2 R7";
        ltag = (mid_st >= 0) ? "R10 R4" : ((ek == 0) ? "R3" : "R4");
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(k);
        req_wide  = wide;
        req_addr  = a;
        req_wdata = wd;
        hiport    = hp;
        ad_in     = ~bv;
        @(posedge clk);
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (t == 0) begin
                req_valid = 1'b0;
                req_addr  = ~a;
                req_wdata = ~wd;
                hiport    = ~hp;
            end
            check({ale, psen_n, rd_n, wr_n, ad_oe} == exp_ctrl(ek, t, len), tag,
                  $sformatf("strobes t=%0d", t),
                  {ale, psen_n, rd_n, wr_n, ad_oe}, exp_ctrl(ek, t, len));
            if (exp_ctrl(ek, t, len)[0])
                check(ad_out == exp_bus(ek, t, a, wd), tag,
                      $sformatf("bus t=%0d", t), ad_out, exp_bus(ek, t, a, wd));
            check(addr_hi == ehi, "R8", $sformatf("addr_hi t=%0d", t), addr_hi, ehi);
            check(ready == (t == len - 1), ltag, $sformatf("ready t=%0d", t),
                  ready, (t == len - 1));
            if (t == len - 1 && ek != 2)
                check(rdata == bv, "R9", "rdata at ready", rdata, bv);
            if (t == 1) ad_in = bv;
            if (t == chg) ad_in = ~bv;
            if (mid_st >= 0 && t == 1) begin
                stretch_we    = 1'b1;
                stretch_wdata = 3'(mid_st);
            end
            if (mid_st >= 0 && t == 2) stretch_we = 1'b0;
        end
        if (mid_st >= 0) cur_st = mid_st;
        @(negedge clk);
        check({ale, psen_n, rd_n, wr_n, ad_oe, ready} == 6'b011100, "R9",
              "idle after access", {ale, psen_n, rd_n, wr_n, ad_oe, ready}, 6'b011100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog: actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd90210));
        repeat (3) @(negedge clk);
        // R1 reset values
        check({ale, psen_n, rd_n, wr_n, ad_oe, ready} == 6'b111110, "R1",
              "reset strobes", {ale, psen_n, rd_n, wr_n, ad_oe, ready}, 6'b111110);
        check(ad_out == 8'hFF, "R1", "reset bus", ad_out, 8'hFF);
        check(addr_hi == 8'hFF, "R1", "reset addr_hi", addr_hi, 8'hFF);
        @(negedge clk);
        rst = 1'b0;

        // R4 reset stretch of 1 gives a 12-clock read; R8 narrow uses hiport
        access(1, 1'b0, 16'h1234, 8'h00, 8'hA5, 8'h3C, -1);
        // R3 fetch ignores hiport
        access(0, 1'b0, 16'hBEEF, 8'h00, 8'h11, 8'hC3, -1);
        // R6 wide write
        access(2, 1'b1, 16'h8001, 8'h5A, 8'h22, 8'h00, -1);
        // R4 minimum length
        set_stretch(0);
        access(1, 1'b1, 16'h4321, 8'h00, 8'h00, 8'h96, -1);
        access(2, 1'b0, 16'h00FF, 8'hE7, 8'h7E, 8'h00, -1);
        // R4 maximum length
        set_stretch(7);
        access(2, 1'b1, 16'hFFFF, 8'h81, 8'h00, 8'h00, -1);
        // R5 code 11 behaves as read
        access(3, 1'b0, 16'h0F0F, 8'h00, 8'hD2, 8'h69, -1);
        // R10 stretch changed mid-access
        set_stretch(2);
        access(1, 1'b1, 16'h2468, 8'h00, 8'h00, 8'hA1, 5);
        access(2, 1'b1, 16'h1357, 8'h4B, 8'h00, 8'h00, -1);

        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 4) == 0) set_stretch($urandom_range(0, 7));
            access($urandom_range(0, 3), 1'($urandom), 16'($urandom), 8'($urandom),
                   8'($urandom), 8'($urandom), -1);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule